// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one general-purpose I/O port of up to sixteen pins, controlled through a word-addressed 32-bit register interface. Software sets each pin's direction and output level, and reads back the current pin levels through a two-flop synchronizer. Every pin also has its own interrupt path. A 3-bit trigger code selects falling edge, rising edge, both edges, low level or high level. An enable bit gates whether events are latched. Latched events sit in a status bit that is cleared by writing one. A per-pin mask is set and cleared through two separate write-one registers.

The masked view of status is readable as a display word. A single interrupt line is the OR of that view. A soft reset word holds every software-visible register at zero while its bit is one. Writing one and then zero to it returns the port to its power-up state. The input synchronizers are not cleared by the soft reset.

Top module: `gpio_irq_port`

## Requirements
- R1: Word addresses: 0 enable, 1 status, 2 display, 3 status clear, 4 mask set (reads the mask), 5 mask clear (reads 0), 6 output data, 7 input data, 8 direction, 9 mode register 0, 10 mode register 1, 11 reserved (reads 0), 12 soft reset (bit 0, reads back). Every word reads zero after reset, and the interrupt line is low.
- R2: The direction register drives `pinOe` and the output data register drives `pinOut`. A direction bit of 1 makes a pin an output. Bits at or above `PORT_W` in the direction and output words read as zero.
- R3: The input data word returns the pin levels after a two-flop synchronizer. A level driven between clock edges appears after the second following rising edge.
- R4: Trigger codes are 0 falling edge, 1 rising edge, 2 level low, 3 level high and 4 both edges. Codes 5 to 7 never set status.
- R5: Pin p below 8 keeps its code in mode register 0 bits [4p+2:4p]. Pin p of 8 or above keeps its code in mode register 1 bits [4(p-8)+2:4(p-8)]. The top bit of each 4-bit slot, and the slots of pins beyond `PORT_W`, read as zero.
- R6: A status bit is set only while that pin's enable bit is 1.
- R7: In a level mode, a status bit cleared while the level still holds is set again at once. An edge-mode status bit stays set after the pin settles, until it is cleared.
- R8: Writing 1 to a bit of the status clear word clears that status bit. Zero bits leave status unchanged.
- R9: Writing 1 to a mask set bit masks that pin, and writing 1 to the same mask clear bit unmasks it. Zero bits leave the mask unchanged.
- R10: The display word equals status AND NOT mask. `irqOut` is high exactly when the display word is nonzero.
- R11: While soft reset bit 0 is 1, enable, status, mask, output data, direction and modes are held at zero. After 0 is written, the registers accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pinIn | input | PORT_W | Pin levels from the pads |
| pinOut | output | PORT_W | Output levels to the pads |
| pinOe | output | PORT_W | Output enables (1 = drive) |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pinIn` may change at any time, because it passes through the synchronizer. They also assume that `wrEn` and `addr` are stable around the rising clock edge, and that at most one word is written per cycle. The bench drives pins and bus signals only at falling edges and writes a single word per task call. It waits at least six cycles after any pin change before it judges status, so the synchronizer and edge detector have settled. Random trials place one enabled pin at a time under a random trigger code, mask, and starting and ending level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MAX_PINS = 16;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned PINS_PER_MODE = DATA_W / SLOT_W;

  localparam logic [ADDR_W-1:0] A_IEN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DISP  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MSET  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCLR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DOUT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DIN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_DIR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_MODE0 = 4'd9;
  localparam logic [ADDR_W-1:0] A_MODE1 = 4'd10;
  localparam logic [ADDR_W-1:0] A_SRST  = 4'd12;

  localparam logic [2:0] TRIG_FALL = 3'd0;
  localparam logic [2:0] TRIG_RISE = 3'd1;
  localparam logic [2:0] TRIG_LOW  = 3'd2;
  localparam logic [2:0] TRIG_HIGH = 3'd3;
  localparam logic [2:0] TRIG_BOTH = 3'd4;

  typedef struct packed {
    logic wrIen;
    logic wrClr;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrDout;
    logic wrDir;
    logic wrMode0;
    logic wrMode1;
    logic softClr;
  } strobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              srstBit,
  output strobe_t           stb,
  output logic              srstQ
);

  logic srstWr;
  assign srstWr = wrEn && (addr == A_SRST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srstQ <= 1'b0;
    else if (srstWr) srstQ <= srstBit;
  end

  always_comb begin
    stb.wrIen     = wrEn && (addr == A_IEN);
    stb.wrClr     = wrEn && (addr == A_CLR);
    stb.wrMaskSet = wrEn && (addr == A_MSET);
    stb.wrMaskClr = wrEn && (addr == A_MCLR);
    stb.wrDout    = wrEn && (addr == A_DOUT);
    stb.wrDir     = wrEn && (addr == A_DIR);
    stb.wrMode0   = wrEn && (addr == A_MODE0);
    stb.wrMode1   = wrEn && (addr == A_MODE1);
    stb.softClr   = srstQ;
  end

  // R1: one word written per cycle
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrIen, stb.wrClr, stb.wrMaskSet, stb.wrMaskClr,
              stb.wrDout, stb.wrDir, stb.wrMode0, stb.wrMode1}));

  // R11: soft reset bit follows its last write
  a_r11_srst_follows: assert property (@(posedge clk) disable iff (!rstN)
    srstWr |=> (srstQ == $past(srstBit)));

endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinRaw,
  input  logic [2:0] mode,
  output logic       pinLvl,
  output logic       evt
);

  logic syncA;
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      pinLvl  <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncA   <= pinRaw;
      pinLvl  <= syncA;
      prevLvl <= pinLvl;
    end
  end

  logic rise, fall;
  assign rise = pinLvl & ~prevLvl;
  assign fall = ~pinLvl & prevLvl;

  always_comb begin
    case (mode)
      TRIG_FALL: evt = fall;
      TRIG_RISE: evt = rise;
      TRIG_LOW:  evt = ~pinLvl;
      TRIG_HIGH: evt = pinLvl;
      TRIG_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  // R4: edge-mode events only when the synchronized level moved
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    (evt && mode != TRIG_LOW && mode != TRIG_HIGH) |-> (pinLvl != $past(pinLvl)));

  // R4: undefined codes never fire
  a_r4_undefined_silent: assert property (@(posedge clk) disable iff (!rstN)
    (mode > TRIG_BOTH) |-> !evt);

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              srstQ,
  input  logic [PORT_W-1:0] pinIn,
  output logic [DATA_W-1:0] rdata,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic              irqOut
);

  logic [PORT_W-1:0] wd;
  logic [PORT_W-1:0] ienQ, statusQ, maskQ, doutQ, dirQ;
  logic [PORT_W-1:0] evt, pinLvl, dispW, clrBits, statusNext;
  logic [MAX_PINS-1:0][SLOT_W-1:0] slotAll;
  wire unusedWdata = ^wdata;

  assign wd = wdata[PORT_W-1:0];

  for (genvar p = 0; p < MAX_PINS; p++) begin : g_pin
    if (p < PORT_W) begin : g_live
      localparam int unsigned SLOT = (p % PINS_PER_MODE) * SLOT_W;
      localparam bit HIGH_REG = (p >= PINS_PER_MODE);
      logic [2:0] modeQ;
      logic       modeWr;
      assign modeWr = HIGH_REG ? stb.wrMode1 : stb.wrMode0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            modeQ <= 3'd0;
        else if (stb.softClr) modeQ <= 3'd0;
        else if (modeWr)      modeQ <= wdata[SLOT +: 3];
      end

      gpio_irq_trig u_trig (
        .clk   (clk),
        .rstN  (rstN),
        .pinRaw(pinIn[p]),
        .mode  (modeQ),
        .pinLvl(pinLvl[p]),
        .evt   (evt[p])
      );

      assign slotAll[p] = {1'b0, modeQ};
    end else begin : g_absent
      assign slotAll[p] = '0;
    end
  end

  assign clrBits    = stb.wrClr ? wd : '0;
  assign statusNext = (statusQ & ~clrBits) | (evt & ienQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ <= '0; statusQ <= '0; maskQ <= '0; doutQ <= '0; dirQ <= '0;
    end else if (stb.softClr) begin
      ienQ <= '0; statusQ <= '0; maskQ <= '0; doutQ <= '0; dirQ <= '0;
    end else begin
      if (stb.wrIen)  ienQ  <= wd;
      if (stb.wrDout) doutQ <= wd;
      if (stb.wrDir)  dirQ  <= wd;
      if (stb.wrMaskSet)      maskQ <= maskQ | wd;
      else if (stb.wrMaskClr) maskQ <= maskQ & ~wd;
      statusQ <= statusNext;
    end
  end

  assign dispW  = statusQ & ~maskQ;
  assign irqOut = |dispW;
  assign pinOut = doutQ;
  assign pinOe  = dirQ;

  always_comb begin
    case (addr)
      A_IEN:   rdata = DATA_W'(ienQ);
      A_STAT:  rdata = DATA_W'(statusQ);
      A_DISP:  rdata = DATA_W'(dispW);
      A_MSET:  rdata = DATA_W'(maskQ);
      A_DOUT:  rdata = DATA_W'(doutQ);
      A_DIN:   rdata = DATA_W'(pinLvl);
      A_DIR:   rdata = DATA_W'(dirQ);
      A_MODE0: rdata = slotAll[PINS_PER_MODE-1:0];
      A_MODE1: rdata = slotAll[MAX_PINS-1:PINS_PER_MODE];
      A_SRST:  rdata = {{(DATA_W-1){1'b0}}, srstQ};
      default: rdata = '0;
    endcase
  end

  // R6: new status bits only on enabled pins
  a_r6_status_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(ienQ)) == '0));

  // R8: cleared bits stay cleared unless a fresh event arrives
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrClr && !stb.softClr) |=>
      ((statusQ & $past(wd) & ~$past(evt & ienQ)) == '0));

  // R9: mask set and clear
  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMaskSet && !stb.softClr) |=> ((maskQ & $past(wd)) == $past(wd)));
  a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMaskClr && !stb.softClr) |=> ((maskQ & $past(wd)) == '0));

  // R10: fully masked port keeps the line low
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut);

  // R11: soft reset empties the port registers
  a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.softClr |=> (ienQ == '0 && statusQ == '0 && maskQ == '0 &&
                     doutQ == '0 && dirQ == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic              irqOut
);

  strobe_t stb;
  logic    srstQ;

  gpio_irq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .srstBit(wdata[0]),
    .stb    (stb),
    .srstQ  (srstQ)
  );

  gpio_irq_dp #(.PORT_W(PORT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (wdata),
    .addr  (addr),
    .srstQ (srstQ),
    .pinIn (pinIn),
    .rdata (rdata),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .irqOut(irqOut)
  );

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

  localparam int PW = 12;
  localparam logic [31:0] PMASK = (32'd1 << PW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [PW-1:0] pinIn = '0;
  logic [PW-1:0] pinOut, pinOe;
  logic irqOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port #(.PORT_W(PW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drivePins(input logic [PW-1:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  function automatic bit edgeHit(input int mode, input bit o, input bit n);
    case (mode)
      0: return o && !n;
      1: return !o && n;
      4: return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit levelHit(input int mode, input bit n);
    return (mode == 2) ? !n : (mode == 3) ? n : 1'b0;
  endfunction

  function automatic logic [31:0] modeWord(input int pin, input int code);
    return 32'(code) << (4 * (pin % 8));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog all actual=timeout expected=complete");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    waitClk(3);
    @(negedge clk); rstN = 1'b1;
    waitClk(2);

    // R1: reset state of every word
    for (int a = 0; a <= 12; a++) begin
      rd(4'(a), d);
      check("R1 reset word", d, 32'd0);
    end
    check("R1 irq low at reset", {31'd0, irqOut}, 32'd0);
    check("R2 oe low at reset", 32'(pinOe), 32'd0);

    // R2: direction and output data
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d);
    check("R2 dir width", d, PMASK);
    check("R2 pinOe", 32'(pinOe), PMASK);
    wr(4'd6, 32'hFFFF_F5A5);
    rd(4'd6, d);
    check("R2 dout width", d, 32'h5A5);
    check("R2 pinOut", 32'(pinOut), 32'h5A5);
    wr(4'd8, 32'd0);

    // R3: synchronized readback latency
    drivePins(12'hABC);
    @(posedge clk); #1;
    addr = 4'd7; #0.5;
    check("R3 not yet after one edge", rdata, 32'd0);
    @(posedge clk); #1;
    check("R3 din after two edges", rdata, 32'hABC);
    drivePins(12'h000);
    waitClk(4);

    // R5: mode slot layout
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, d);
    check("R5 mode0 slots", d, 32'h7777_7777);
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, d);
    check("R5 mode1 absent pins", d, 32'h0000_7777);
    wr(4'd9, modeWord(3, 3));
    rd(4'd9, d);
    check("R5 pin3 slot", d, 32'h0000_3000);
    wr(4'd10, 32'd0);

    // R1: mask clear and reserved read zero; R9 mask set/clear
    wr(4'd4, 32'h0F0);
    rd(4'd4, d);
    check("R9 mask set", d, 32'h0F0);
    wr(4'd5, 32'h030);
    rd(4'd4, d);
    check("R9 mask clear", d, 32'h0C0);
    rd(4'd5, d);
    check("R1 mask clear reads zero", d, 32'd0);
    rd(4'd11, d);
    check("R1 reserved reads zero", d, 32'd0);
    wr(4'd5, 32'hFFFF_FFFF);

    // R6: disabled pin never latches
    wr(4'd9, modeWord(2, 1));
    wr(4'd0, 32'd0);
    drivePins(12'h004);
    waitClk(6);
    rd(4'd1, d);
    check("R6 disabled no status", d, 32'd0);

    // R8: zero write leaves status, one write clears
    drivePins(12'h000);
    waitClk(6);
    wr(4'd0, 32'h004);
    drivePins(12'h004);
    waitClk(6);
    rd(4'd1, d);
    check("R7 edge stays latched", d, 32'h004);
    check("R10 irq on pending", {31'd0, irqOut}, 32'd1);
    wr(4'd3, 32'h000);
    rd(4'd1, d);
    check("R8 zero write no effect", d, 32'h004);
    wr(4'd3, 32'h004);
    rd(4'd1, d);
    check("R8 one write clears", d, 32'h000);
    check("R10 irq drops", {31'd0, irqOut}, 32'd0);

    // R7: level high keeps re-setting
    wr(4'd9, modeWord(5, 3));
    wr(4'd0, 32'h020);
    drivePins(12'h020);
    waitClk(6);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd1, d);
    check("R7 level re-sets", d, 32'h020);
    drivePins(12'h000);
    waitClk(6);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd1, d);
    check("R7 level gone", d, 32'h000);

    // R4: both edges on pin 7
    wr(4'd9, modeWord(7, 4));
    wr(4'd0, 32'h080);
    drivePins(12'h080);
    waitClk(6);
    rd(4'd1, d);
    check("R4 both rise", d, 32'h080);
    wr(4'd3, 32'h080);
    drivePins(12'h000);
    waitClk(6);
    rd(4'd1, d);
    check("R4 both fall", d, 32'h080);
    wr(4'd3, 32'hFFFF_FFFF);

    // R10: masked pending hides display and irq
    wr(4'd4, 32'h080);
    drivePins(12'h080);
    waitClk(6);
    rd(4'd2, d);
    check("R10 display masked", d, 32'd0);
    check("R10 irq masked", {31'd0, irqOut}, 32'd0);
    wr(4'd5, 32'h080);
    rd(4'd2, d);
    check("R10 display unmasked", d, 32'h080);

    // R11: soft reset
    wr(4'd8, 32'h0F0);
    wr(4'd6, 32'h00F);
    wr(4'd12, 32'd1);
    rd(4'd12, d);
    check("R11 srst readback", d, 32'd1);
    wr(4'd6, 32'h111);
    for (int a = 0; a <= 10; a++) begin
      if (a == 7) continue;
      rd(4'(a), d);
      check("R11 held zero", d, 32'd0);
    end
    wr(4'd12, 32'd0);
    wr(4'd6, 32'h222);
    rd(4'd6, d);
    check("R11 writes after release", d, 32'h222);
    wr(4'd6, 32'd0);
    drivePins(12'h000);
    waitClk(4);

    // Random trials: one enabled pin, random code, mask and levels
    for (int it = 0; it < 60; it++) begin
      int pin, mode;
      bit en, msk, o, n, expS;
      logic [31:0] st, dp;
      pin  = int'($urandom % PW);
      mode = int'($urandom % 6);
      en   = ($urandom % 4) != 0;
      msk  = $urandom % 2;
      o    = $urandom % 2;
      n    = $urandom % 2;
      wr(4'd0, 32'd0);
      wr(4'd9, 32'd0);
      wr(4'd10, 32'd0);
      wr(pin < 8 ? 4'd9 : 4'd10, modeWord(pin, mode));
      drivePins(PW'(o) << pin);
      waitClk(6);
      wr(4'd0, 32'(en) << pin);
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd5, 32'hFFFF_FFFF);
      if (msk) wr(4'd4, 32'd1 << pin);
      drivePins(PW'(n) << pin);
      waitClk(6);
      if (mode == 2 || mode == 3) begin
        wr(4'd3, 32'hFFFF_FFFF);
        expS = en && levelHit(mode, n);
      end else begin
        expS = en && edgeHit(mode, o, n);
      end
      rd(4'd1, st);
      check("R4 R6 random status", st, 32'(expS) << pin);
      rd(4'd2, dp);
      check("R10 random display", dp, 32'(expS && !msk) << pin);
      check("R10 random irq", {31'd0, irqOut}, {31'd0, expS && !msk});
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule